// File: doc/BRIEF.md
# Coherent Sample Register Lock

This block sits between a measurement engine and a host register-read port. The measurement side delivers three-axis samples as 48-bit words with a one-cycle strobe. The block keeps the latest sample in six byte-wide output registers. The host reads them one at a time through a small address/enable port. After the host has read some but not all six bytes, the bank is frozen. A sample that arrives during that time cannot mix new bytes with old ones. It waits in a one-deep holding slot, and a later arrival replaces it.

The freeze ends when one of these happens:
- all six bytes have been read;
- the operating mode changes;
- a measurement-configuration change pulse arrives;
- reset.

A read-only status word reports three flags: regulator-enabled, lock and ready. A data-ready pin repeats the ready flag. Each time the ready indication drops, it stays low for a programmable number of clock cycles. This models a minimum low time in real units (5 µs at the default parameters).

Top module: `coherent_sample_lock`

## Requirements
- R1: Addresses 0 to 5 return byte k of the held sample, data bits [8k+7:8k]. Address 6 returns the status word. Address 7 returns zero. Reading is combinational from the current address.
- R2: The status word is {5'b0, regulator flag, lock flag, ready flag}: bit 2 regulator, bit 1 lock, bit 0 ready, bits 7..3 always zero. Reading address 6 does not count as a data read.
- R3: The lock flag is set when at least one, but not all six, of the data bytes has been read since the last load or release. Once all six have been read, further reads of the same sample do not set the lock again.
- R4: While the bank is locked, the six data bytes keep their value. Arriving samples go to the holding slot, and only the newest one is kept.
- R5: The read that completes the set of six releases the lock. At that same clock edge, the held sample (or one arriving in that cycle) is loaded.
- R6: A change of op_mode or a cfg_change pulse releases the lock and clears the read record. A waiting or arriving sample is loaded at that edge, and a read in that cycle is not recorded.
- R7: After a load, the ready flag and drdy rise exactly HOLD_CYC clock edges later, provided no further load and no off mode intervene. drdy always equals status bit 0.
- R8: Every load drops ready and restarts the full HOLD_CYC low interval. Ready never stays low for fewer than HOLD_CYC cycles.
- R9: op_mode 2'b11 (off) forces ready low and marks the held sample as stale. After leaving off mode, ready returns only HOLD_CYC edges after a new load.
- R10: Status bit 2 follows the reg_on input.
- R11: Reset clears every data byte, the holding slot, the read record and all flags. The hold counter starts expired.
- R12: When a data read and a sample arrival fall in the same cycle, the read is counted first. If it leaves the record partial, the sample is held back rather than loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_valid | input | 1 | New-sample strobe, one cycle |
| smp_data | input | 48 | Sample word, byte k at bits [8k+7:8k] |
| op_mode | input | 2 | Operating mode, 2'b11 = off |
| cfg_change | input | 1 | Measurement-configuration change pulse |
| reg_on | input | 1 | Internal regulator is on |
| rd_en | input | 1 | Host read strobe |
| rd_addr | input | 3 | Host read address |
| rd_data | output | 8 | Read data for rd_addr |
| drdy | output | 1 | Data-ready pin |

## Verification
Two events can fall in the same cycle: a host data read and a sample strobe. The bench triggers this on a freshly loaded, unread bank by issuing both in the same cycle. It then judges the outcome from the byte read next, which must still come from the older sample, and from the lock flag. A second overlap pairs the completing sixth read with a held sample. That sample must be visible on the very next read.

// File: rtl/csl_pkg.sv
// Shared constants and helpers for the coherent sample lock.
// Assumes a fixed six-byte bank addressed 0..5 with status at address 6.
package csl_pkg;
    localparam int NBYTES  = 6;
    localparam int BYTE_W  = 8;
    localparam int SMP_W   = NBYTES * BYTE_W;
    localparam int ADDR_W  = 3;
    localparam logic [ADDR_W-1:0] ADDR_STATUS = 3'd6;
    localparam logic [NBYTES-1:0] MASK_FULL   = {NBYTES{1'b1}};

    typedef enum logic [1:0] {
        MODE_CONT   = 2'b00,
        MODE_SINGLE = 2'b01,
        MODE_IDLE   = 2'b10,
        MODE_OFF    = 2'b11
    } op_mode_e;

    // True when some but not all bytes are marked as read.
    function automatic logic is_partial(input logic [NBYTES-1:0] m);
        return (m != '0) && (m != MASK_FULL);
    endfunction
endpackage

// File: rtl/csl_read_track.sv
// Records which data bytes the host has read since the last load or release.
// Assumes rd_hit is asserted only for data addresses (below NBYTES).
module csl_read_track
    import csl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_hit,
    input  logic [ADDR_W-1:0] rd_idx,
    input  logic              clear,
    output logic              partial_now,
    output logic              lock
);
    logic [NBYTES-1:0] mask_q;
    logic [NBYTES-1:0] hit_vec;
    logic [NBYTES-1:0] mask_rd;

    // One decode bit per data byte.
    for (genvar k = 0; k < NBYTES; k++) begin : g_hit
        assign hit_vec[k] = rd_hit && (rd_idx == ADDR_W'(k));
    end

    // Record including this cycle's read, used to decide whether a load may proceed.
    always_comb begin
        mask_rd     = mask_q | hit_vec;
        partial_now = is_partial(mask_rd);
        lock        = is_partial(mask_q);
    end

    // Keep the record, or clear it on load or release.
    always_ff @(posedge clk) begin
        if (!rst_n)     mask_q <= '0;
        else if (clear) mask_q <= '0;
        else            mask_q <= mask_rd;
    end
endmodule

// File: rtl/csl_bank.sv
// Six-byte output bank with a one-deep holding slot for blocked samples.
// Assumes blocked is valid in the same cycle as smp_valid; the newest sample wins.
module csl_bank
    import csl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_valid,
    input  logic [SMP_W-1:0] smp_data,
    input  logic             blocked,
    output logic             load,
    output logic [SMP_W-1:0] bank_q
);
    logic             pend_v;
    logic [SMP_W-1:0] pend_d;
    logic [SMP_W-1:0] src_d;

    // Pick the newest available sample and decide whether it goes in now.
    always_comb begin
        src_d = smp_valid ? smp_data : pend_d;
        load  = (smp_valid || pend_v) && !blocked;
    end

    // Load the bank when allowed.
    always_ff @(posedge clk) begin
        if (!rst_n)    bank_q <= '0;
        else if (load) bank_q <= src_d;
    end

    // Park a blocked arrival; drop the slot once its content (or a newer one) is loaded.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_v <= 1'b0;
            pend_d <= '0;
        end else if (smp_valid && blocked) begin
            pend_v <= 1'b1;
            pend_d <= smp_data;
        end else if (load) begin
            pend_v <= 1'b0;
        end
    end
endmodule

// File: rtl/csl_ready_timer.sv
// Ready flag with a minimum low interval of HOLD_CYC cycles after each drop.
// Assumes HOLD_CYC >= 1; a load or off mode drops the flag and restarts the count.
module csl_ready_timer #(
    parameter int HOLD_CYC = 625
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic off,
    output logic rdy
);
    localparam int CNT_W = $clog2(HOLD_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_RELOAD = CNT_W'(HOLD_CYC);

    logic [CNT_W-1:0] cnt_q, cnt_nxt;
    logic             fresh_q, fresh_nxt;
    logic             lower;

    // Next state of the hold counter and of the fresh-data flag.
    always_comb begin
        lower     = load || off;
        cnt_nxt   = lower ? CNT_RELOAD : ((cnt_q != '0) ? cnt_q - 1'b1 : '0);
        fresh_nxt = load ? 1'b1 : (off ? 1'b0 : fresh_q);
    end

    // Register the counter, freshness and ready flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            fresh_q <= 1'b0;
            rdy     <= 1'b0;
        end else begin
            cnt_q   <= cnt_nxt;
            fresh_q <= fresh_nxt;
            rdy     <= !lower && fresh_nxt && (cnt_nxt == '0);
        end
    end
endmodule

// File: rtl/coherent_sample_lock.sv
// Top level: host read port, status word, release detection and data-ready pin.
// Assumes rd_en reads are single-cycle and the mode input is synchronous to clk.
module coherent_sample_lock
    import csl_pkg::*;
#(
    parameter int HOLD_CYC = 625
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_valid,
    input  logic [SMP_W-1:0]  smp_data,
    input  logic [1:0]        op_mode,
    input  logic              cfg_change,
    input  logic              reg_on,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [BYTE_W-1:0] rd_data,
    output logic              drdy
);
    logic [1:0]        mode_q;
    logic              mode_chg, release_evt, rd_hit;
    logic              partial_now, lock_q, blocked, load, clear;
    logic              off, rdy_q;
    logic [SMP_W-1:0]  bank_q;
    logic [BYTE_W-1:0] status_w;
    logic [BYTE_W-1:0] bytes_w [NBYTES];

    // Remember the mode to detect a change.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= MODE_CONT;
        else        mode_q <= op_mode;
    end

    // Release, blocking and clearing decisions.
    always_comb begin
        mode_chg    = (op_mode != mode_q);
        release_evt = mode_chg || cfg_change;
        rd_hit      = rd_en && (rd_addr < ADDR_W'(NBYTES));
        blocked     = partial_now && !release_evt;
        clear       = load || release_evt;
        off         = (op_mode == MODE_OFF);
    end

    csl_read_track u_track (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_hit      (rd_hit),
        .rd_idx      (rd_addr),
        .clear       (clear),
        .partial_now (partial_now),
        .lock        (lock_q)
    );

    csl_bank u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_valid (smp_valid),
        .smp_data  (smp_data),
        .blocked   (blocked),
        .load      (load),
        .bank_q    (bank_q)
    );

    csl_ready_timer #(.HOLD_CYC(HOLD_CYC)) u_rdy (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .off   (off),
        .rdy   (rdy_q)
    );

    // Slice the bank into bytes.
    for (genvar k = 0; k < NBYTES; k++) begin : g_bytes
        assign bytes_w[k] = bank_q[k*BYTE_W +: BYTE_W];
    end

    // Compose the status word and select the read data.
    always_comb begin
        status_w = {5'b0, reg_on, lock_q, rdy_q};
        if (rd_addr < ADDR_W'(NBYTES)) rd_data = bytes_w[rd_addr];
        else if (rd_addr == ADDR_STATUS) rd_data = status_w;
        else rd_data = '0;
    end

    assign drdy = rdy_q;
endmodule

// File: rtl/csl_checks.sv
// Property checker for coherent_sample_lock, attached by bind.
module csl_checks #(
    parameter int HOLD_CYC = 625
) (
    input logic        clk,
    input logic        rst_n,
    input logic        drdy,
    input logic        lock_f,
    input logic [47:0] bank,
    input logic [1:0]  op_mode,
    input logic        cfg_change
);
    logic [31:0] low_run;

    // Count consecutive low cycles of drdy.
    always_ff @(posedge clk) begin
        if (!rst_n)                 low_run <= '0;
        else if (drdy)              low_run <= '0;
        else if (low_run != '1)     low_run <= low_run + 1;
    end

    assert_bank_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
        lock_f |=> (!lock_f || $stable(bank)));

    assert_cfg_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_change |=> !lock_f);

    assert_min_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drdy) |-> (low_run >= 32'(HOLD_CYC)));

    assert_off_no_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_mode == 2'b11) |=> !drdy);
endmodule

bind coherent_sample_lock csl_checks #(.HOLD_CYC(HOLD_CYC)) u_checks (
    .clk        (clk),
    .rst_n      (rst_n),
    .drdy       (drdy),
    .lock_f     (lock_q),
    .bank       (bank_q),
    .op_mode    (op_mode),
    .cfg_change (cfg_change)
);

// File: tb/coherent_sample_lock_test.sv
module coherent_sample_lock_test;
    localparam int H = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_valid = 1'b0;
    logic [47:0] smp_data = '0;
    logic [1:0]  op_mode = 2'b00;
    logic        cfg_change = 1'b0;
    logic        reg_on = 1'b0;
    logic        rd_en = 1'b0;
    logic [2:0]  rd_addr = '0;
    logic [7:0]  rd_data;
    logic        drdy;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    coherent_sample_lock #(.HOLD_CYC(H)) uut (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
        .op_mode(op_mode), .cfg_change(cfg_change), .reg_on(reg_on),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .drdy(drdy)
    );

    always #4 clk = ~clk;

    localparam logic [47:0] SA = 48'h A5A4_A3A2_A1A0;
    localparam logic [47:0] SB = 48'h B5B4_B3B2_B1B0;
    localparam logic [47:0] SC = 48'h C5C4_C3C2_C1C0;
    localparam logic [47:0] SD = 48'h D5D4_D3D2_D1D0;
    localparam logic [47:0] SE = 48'h E5E4_E3E2_E1E0;
    localparam logic [47:0] SF = 48'h F5F4_F3F2_F1F0;
    localparam logic [47:0] SG = 48'h 1514_1312_1110;
    localparam logic [47:0] SG2 = 48'h 2524_2322_2120;
    localparam logic [47:0] SY = 48'h 3534_3332_3130;

    function automatic logic [7:0] byte_of(input logic [47:0] s, input int k);
        return s[k*8 +: 8];
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick(); @(negedge clk); endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        rd_en = 1'b1; rd_addr = a; #1 d = rd_data;
        tick();
        rd_en = 1'b0;
    endtask

    task automatic push(input logic [47:0] s);
        smp_valid = 1'b1; smp_data = s;
        tick();
        smp_valid = 1'b0;
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic t_reset();
        logic [7:0] d;
        for (int k = 0; k < 8; k++) begin
            rd(3'(k), d);
            chk("R11 reset read", d, 8'h00);
        end
        chk("R11 reset drdy", drdy, 1'b0);
    endtask

    task automatic t_basic();
        logic [7:0] d;
        push(SA);
        chk("R7 drdy low after load", drdy, 1'b0);
        wait_n(H - 1);
        chk("R7 drdy before hold end", drdy, 1'b0);
        tick();
        chk("R7 drdy at hold end", drdy, 1'b1);
        rd(3'd6, d);
        chk("R7 status ready bit", d, 8'h01);
        rd(3'd0, d); chk("R1 byte0", d, byte_of(SA, 0));
        rd(3'd1, d); chk("R1 byte1", d, byte_of(SA, 1));
        rd(3'd2, d); chk("R1 byte2", d, byte_of(SA, 2));
        rd(3'd6, d);
        chk("R3 lock after partial read", d, 8'h03);
        rd(3'd3, d); rd(3'd4, d); rd(3'd5, d);
        chk("R1 byte5", d, byte_of(SA, 5));
        rd(3'd6, d);
        chk("R3 lock cleared after full set", d, 8'h01);
        rd(3'd2, d); rd(3'd6, d);
        chk("R3 no relock after full set", d, 8'h01);
    endtask

    task automatic t_lock();
        logic [7:0] d;
        push(SA);
        wait_n(H);
        rd(3'd0, d);
        chk("R4 first byte A", d, byte_of(SA, 0));
        push(SB);
        chk("R4 drdy kept while locked", drdy, 1'b1);
        push(SC);
        for (int k = 1; k < 5; k++) begin
            rd(3'(k), d);
            chk("R4 bank holds A", d, byte_of(SA, k));
        end
        rd(3'd5, d);
        chk("R5 last byte still A", d, byte_of(SA, 5));
        rd(3'd0, d);
        chk("R5 newest held sample loaded", d, byte_of(SC, 0));
        chk("R8 drdy dropped by load", drdy, 1'b0);
        rd(3'd6, d);
        chk("R3 lock after one read", d[1], 1'b1);
    endtask

    task automatic t_release();
        logic [7:0] d;
        push(SD);
        cfg_change = 1'b1; tick(); cfg_change = 1'b0;
        rd(3'd6, d);
        chk("R6 cfg release clears lock", d[1], 1'b0);
        rd(3'd2, d);
        chk("R6 cfg release loads held", d, byte_of(SD, 2));
        push(SE);
        rd(3'd6, d);
        chk("R4 still locked after E", d[1], 1'b1);
        op_mode = 2'b01; tick();
        rd(3'd6, d);
        chk("R6 mode change clears lock", d[1], 1'b0);
        rd(3'd3, d);
        chk("R6 mode change loads held", d, byte_of(SE, 3));
        op_mode = 2'b00; tick();
    endtask

    task automatic t_off();
        logic [7:0] d;
        wait_n(H + 2);
        chk("R7 ready before off", drdy, 1'b1);
        op_mode = 2'b11; tick();
        chk("R9 off drops drdy", drdy, 1'b0);
        wait_n(20);
        rd(3'd6, d);
        chk("R9 status ready low in off", d[0], 1'b0);
        op_mode = 2'b00; tick();
        wait_n(H + 2);
        chk("R9 no ready without new load", drdy, 1'b0);
        push(SF);
        wait_n(H - 1);
        chk("R7 drdy before hold end after off", drdy, 1'b0);
        tick();
        chk("R7 drdy returns after load", drdy, 1'b1);
    endtask

    task automatic t_minlow();
        push(SG);
        wait_n(H / 2);
        push(SG2);
        wait_n(H - 1);
        chk("R8 restart holds drdy low", drdy, 1'b0);
        tick();
        chk("R8 drdy after restarted hold", drdy, 1'b1);
    endtask

    task automatic t_collide();
        logic [7:0] d;
        rd_en = 1'b1; rd_addr = 3'd0; smp_valid = 1'b1; smp_data = SY;
        #1 d = rd_data;
        tick();
        rd_en = 1'b0; smp_valid = 1'b0;
        chk("R12 colliding read sees old", d, byte_of(SG2, 0));
        rd(3'd1, d);
        chk("R12 sample held back", d, byte_of(SG2, 1));
        rd(3'd6, d);
        chk("R12 lock set by colliding read", d[1], 1'b1);
        for (int k = 2; k < 6; k++) rd(3'(k), d);
        rd(3'd0, d);
        chk("R5 held sample after completion", d, byte_of(SY, 0));
    endtask

    task automatic t_misc();
        logic [7:0] d;
        reg_on = 1'b1;
        rd(3'd6, d);
        chk("R10 regulator flag", d[2], 1'b1);
        chk("R2 status pad bits zero", d[7:3], 5'b0);
        chk("R2 drdy mirrors status", drdy, d[0]);
        rd(3'd7, d);
        chk("R1 address 7 zero", d, 8'h00);
        reg_on = 1'b0;
        rd(3'd6, d);
        chk("R10 regulator flag off", d[2], 1'b0);
    endtask

    initial begin
        wait_n(3);
        rst_n = 1'b1;
        tick();
        t_reset();
        t_basic();
        t_lock();
        t_release();
        t_off();
        t_minlow();
        t_collide();
        t_misc();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule